// File: doc/BRIEF.md
# Dual-Decoder Register Bank with Clear-Then-Load Sequencing

This block is a small register bank in which every register is picked by a 4-bit register code. A transfer names a source code and a destination code. Two decoders turn them into one-hot selections. For each register there are three control lines: a left (data) enable, a right (address) enable and a clear. The source decoder and the destination decoder drive these lines together, and wherever both reach the same line they are ORed. The shared bus is the OR of an external driver with the contents of every register whose enable line is high and which has a read path on that side.

A destination is never written in a single step. A sequencer runs three phases of one cycle each: clear, load and release. During clear and load the destination's clear line is asserted together with its enable, so the register is forced to zero. Whatever the bus does before it settles is lost. The register keeps only the bus value present in the load cycle. Codes 13 to 15 carry no storage; they place the three digits of an external display encoder on the bus. Codes above 7 are only reachable when the request comes from internal microcode sequencing.

Top module: `regbank_ctrl`

## Requirements
- R1: After reset `busy` is low, every line in `en_left`, `en_right` and `clr_line` is low, and every storage register reads back as zero.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` then stays high for exactly three cycles (clear, load, release) and falls after them.
- R3: Bit n of each line vector belongs to code n. In the clear and load cycles the selected source's enable and the destination's enable and clear lines are high. In the release cycle and while idle every line is low, and a clear line is never high without the enable of the same register.
- R4: The destination ends up with the bus value of the load cycle alone. Its previous contents and any bus value present in the clear cycle have no effect on the result.
- R5: The bus `bus_out` is the bitwise OR of `ext_in` and every register enabled on a side where it has a read path. A read leaves the source unchanged.
- R6: Code 0 selects no register. It drives no line and adds nothing to the bus.
- R7: With `micro` low, codes 8 to 15 act like code 0 both as source and as destination: no line is driven, the bus gets nothing from them and nothing is stored.
- R8: Code 12 (status) accepts clear and load as a destination on the left side. As a source it drives no enable line and contributes zero to the bus.
- R9: Codes 13, 14 and 15 put `virt_in[7:0]`, `[15:8]` and `[23:16]` on the bus as sources. As destinations they drive no line and store nothing.
- R10: With `path_r` high the transfer uses the right enable lines instead of the left ones. Only codes 1 to 9 have a right path, so any other code drives no right line, reads as zero and is not written.
- R11: A `start` that arrives while `busy` is high is ignored. No second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the codes presented this cycle |
| micro | input | 1 | Request comes from microcode; allows codes 8 to 15 |
| path_r | input | 1 | 1 = right (address) path, 0 = left (data) path |
| src_code | input | 4 | Source register code |
| dst_code | input | 4 | Destination register code |
| ext_in | input | 8 | External bus driver, ORed onto the bus |
| virt_in | input | 24 | Display encoder digits for codes 13, 14, 15 |
| busy | output | 1 | Transfer in progress |
| en_left | output | 16 | Left enable line per code (bit 0 unused) |
| en_right | output | 16 | Right enable line per code (bit 0 unused) |
| clr_line | output | 16 | Clear line per code (bit 0 unused) |
| bus_out | output | 8 | Shared bus value |

## Verification
The assertions check on every cycle that the lines are quiet while idle, that a clear never appears without its enable, that `busy` lasts exactly three cycles, and that virtual and status codes never get clear or right lines. They also check that a user-level request aimed above code 7 raises no clear. Only the bench scenarios can show what a register holds after a transfer. Those scenarios cover capture of the load-cycle value over an earlier glitch and over older contents, the OR of external data with source data, and the rejection of writes on a path that the destination lacks.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int CODE_W        = 4;
  localparam int NCODE         = 1 << CODE_W;
  localparam int USER_LAST     = 7;
  localparam int ADDR_LAST     = 9;
  localparam int SRC_LEFT_LAST = 11;
  localparam int PHYS_LAST     = 12;
  localparam int VIRT_FIRST    = 13;
  localparam int N_VIRT        = NCODE - VIRT_FIRST;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CLR  = 2'd1,
    PH_LOAD = 2'd2,
    PH_REL  = 2'd3
  } phase_t;

  function automatic logic [NCODE-1:0] code_span(input int lo, input int hi);
    logic [NCODE-1:0] m;
    m = '0;
    for (int k = 0; k < NCODE; k++) begin
      if (k >= lo && k <= hi) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Per-code capability masks: which codes own which path in which role.
  localparam logic [NCODE-1:0] CAP_SRC_L = code_span(1, SRC_LEFT_LAST) |
                                           code_span(VIRT_FIRST, NCODE-1);
  localparam logic [NCODE-1:0] CAP_SRC_R = code_span(1, ADDR_LAST);
  localparam logic [NCODE-1:0] CAP_DST_L = code_span(1, PHYS_LAST);
  localparam logic [NCODE-1:0] CAP_DST_R = code_span(1, ADDR_LAST);

endpackage

// File: rtl/regbank_decoder.sv
module regbank_decoder
  import regbank_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              priv,
  output logic [NCODE-1:0]  sel
);

  always_comb begin
    sel = '0;
    if (code != '0 && (priv || int'(code) <= USER_LAST)) begin
      sel[code] = 1'b1;
    end
  end

endmodule

// File: rtl/regbank_seq.sv
module regbank_seq
  import regbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   accept
);

  phase_t phase_q, phase_d;

  assign accept = (phase_q == PH_IDLE) && start;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_CLR;
      PH_CLR:  phase_d = PH_LOAD;
      PH_LOAD: phase_d = PH_REL;
      PH_REL:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  phase_t                  phase,
  input  logic [NCODE-1:0]        clr_line,
  input  logic [DATA_W-1:0]       bus_in,
  output logic [NCODE*DATA_W-1:0] q_flat
);

  logic clearing, loading;
  assign clearing = (phase == PH_CLR);
  assign loading  = (phase == PH_LOAD);

  for (genvar c = 0; c < NCODE; c++) begin : g_slot
    if (c >= 1 && c <= PHYS_LAST) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              we;
      logic [DATA_W-1:0] d;
      // Clear forces zero; the load cycle takes the settled bus value.
      assign we = clr_line[c] && (clearing || loading);
      assign d  = loading ? bus_in : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
      end
      assign q_flat[c*DATA_W +: DATA_W] = q;
    end else begin : g_none
      assign q_flat[c*DATA_W +: DATA_W] = '0;
    end
  end

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     micro,
  input  logic                     path_r,
  input  logic [CODE_W-1:0]        src_code,
  input  logic [CODE_W-1:0]        dst_code,
  input  logic [DATA_W-1:0]        ext_in,
  input  logic [N_VIRT*DATA_W-1:0] virt_in,
  output logic                     busy,
  output logic [NCODE-1:0]         en_left,
  output logic [NCODE-1:0]         en_right,
  output logic [NCODE-1:0]         clr_line,
  output logic [DATA_W-1:0]        bus_out
);

  phase_t phase;
  logic   accept;

  logic [CODE_W-1:0] src_q, dst_q;
  logic              path_q, micro_q;

  regbank_seq i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .phase  (phase),
    .accept (accept)
  );

  // Transfer context, captured with an explicit enable on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      path_q  <= 1'b0;
      micro_q <= 1'b0;
    end else if (accept) begin
      src_q   <= src_code;
      dst_q   <= dst_code;
      path_q  <= path_r;
      micro_q <= micro;
    end
  end

  logic [NCODE-1:0] src_sel, dst_sel;

  regbank_decoder i_src_dec (.code(src_q), .priv(micro_q), .sel(src_sel));
  regbank_decoder i_dst_dec (.code(dst_q), .priv(micro_q), .sel(dst_sel));

  logic             active;
  logic [NCODE-1:0] src_l, src_r, dst_l, dst_r;

  assign active = (phase == PH_CLR) || (phase == PH_LOAD);

  always_comb begin
    src_l = '0;
    src_r = '0;
    dst_l = '0;
    dst_r = '0;
    if (active) begin
      if (path_q) begin
        src_r = src_sel & CAP_SRC_R;
        dst_r = dst_sel & CAP_DST_R;
      end else begin
        src_l = src_sel & CAP_SRC_L;
        dst_l = dst_sel & CAP_DST_L;
      end
    end
  end

  // Both decoders meet on the same per-register lines through an OR.
  assign en_left  = src_l | dst_l;
  assign en_right = src_r | dst_r;
  assign clr_line = dst_l | dst_r;
  assign busy     = (phase != PH_IDLE);

  logic [NCODE*DATA_W-1:0] store_q;

  regbank_store #(.DATA_W(DATA_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .clr_line (clr_line),
    .bus_in   (bus_out),
    .q_flat   (store_q)
  );

  // Per-code value offered to the bus: stored, virtual digit, or nothing.
  logic [DATA_W-1:0] slot_val [NCODE];
  logic [NCODE-1:0]  drives;

  for (genvar c = 0; c < NCODE; c++) begin : g_val
    if (c >= VIRT_FIRST) begin : g_virt
      assign slot_val[c] = virt_in[(c-VIRT_FIRST)*DATA_W +: DATA_W];
    end else begin : g_phys
      assign slot_val[c] = store_q[c*DATA_W +: DATA_W];
    end
  end

  assign drives = (en_left & CAP_SRC_L) | (en_right & CAP_SRC_R);

  always_comb begin
    bus_out = ext_in;
    for (int c = 0; c < NCODE; c++) begin
      if (drives[c]) bus_out = bus_out | slot_val[c];
    end
  end

endmodule

// File: rtl/regbank_ctrl_chk.sv
module regbank_ctrl_chk
  import regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              micro,
  input logic [CODE_W-1:0] dst_code,
  input logic              busy,
  input logic [NCODE-1:0]  en_left,
  input logic [NCODE-1:0]  en_right,
  input logic [NCODE-1:0]  clr_line
);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (en_left == '0 && en_right == '0 && clr_line == '0));

  p_clr_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_line & ~(en_left | en_right)) == '0);

  p_busy_three_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ##1 busy ##1 busy ##1 !busy);

  p_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr_line) <= 1 && !clr_line[0] && !en_left[0] && !en_right[0]);

  p_user_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(micro) && $past(dst_code) > 4'd7) |-> clr_line == '0);

  p_virt_nostore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_line[15:13] == 3'b000);

  p_no_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_right[15:10] == 6'b000000);

endmodule

bind regbank_ctrl regbank_ctrl_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .micro    (micro),
  .dst_code (dst_code),
  .busy     (busy),
  .en_left  (en_left),
  .en_right (en_right),
  .clr_line (clr_line)
);

// File: tb/test_regbank_ctrl.sv
module test_regbank_ctrl;

  logic        clk, rst_n, start, micro, path_r;
  logic [3:0]  src_code, dst_code;
  logic [7:0]  ext_in, bus_out;
  logic [23:0] virt_in;
  logic        busy;
  logic [15:0] en_left, en_right, clr_line;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  regbank_ctrl i_regbank_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .micro(micro), .path_r(path_r),
    .src_code(src_code), .dst_code(dst_code), .ext_in(ext_in), .virt_in(virt_in),
    .busy(busy), .en_left(en_left), .en_right(en_right), .clr_line(clr_line),
    .bus_out(bus_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Snapshots of each phase of the last transfer.
  logic [15:0] c_el, c_er, c_clr, l_el, l_er, l_clr, r_el, r_er, r_clr;
  logic [7:0]  l_bus;
  logic        c_busy, l_busy, r_busy, i_busy;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_copy(input logic [3:0] s, input logic [3:0] d, input logic p,
                          input logic m, input logic [7:0] x_clr, input logic [7:0] x_load,
                          input bit poke);
    @(negedge clk);
    src_code = s; dst_code = d; path_r = p; micro = m; ext_in = x_clr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c_el = en_left; c_er = en_right; c_clr = clr_line; c_busy = busy;
    @(posedge clk);
    #1 ext_in = x_load;
    @(negedge clk);
    l_el = en_left; l_er = en_right; l_clr = clr_line; l_bus = bus_out; l_busy = busy;
    if (poke) begin
      src_code = 4'd0; dst_code = 4'd4; micro = 1'b1; path_r = 1'b0; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    r_el = en_left; r_er = en_right; r_clr = clr_line; r_busy = busy;
    @(negedge clk);
    i_busy = busy;
    ext_in = 8'h00;
  endtask

  task automatic write_reg(input logic [3:0] c, input logic [7:0] v);
    run_copy(4'd0, c, 1'b0, 1'b1, v, v, 1'b0);
  endtask

  task automatic read_reg(input logic [3:0] c, input logic p, input logic m,
                          output logic [7:0] v);
    run_copy(c, 4'd0, p, m, 8'h00, 8'h00, 1'b0);
    v = l_bus;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 busy", busy, 0);
    chk("R1 lines", {en_left, en_right, clr_line}, 0);
    for (int c = 1; c <= 11; c++) begin
      read_reg(c[3:0], 1'b0, 1'b1, v);
      chk("R1 reg zero", v, 0);
    end
  endtask

  task automatic t_copy();
    logic [7:0] v;
    write_reg(4'd1, 8'h12);
    write_reg(4'd2, 8'hA5);
    run_copy(4'd1, 4'd2, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
    chk("R3 clr-phase left", c_el, 16'h0006);
    chk("R3 clr-phase clear", c_clr, 16'h0004);
    chk("R3 load-phase left", l_el, 16'h0006);
    chk("R3 load-phase clear", l_clr, 16'h0004);
    chk("R3 release quiet", {r_el, r_er, r_clr}, 0);
    chk("R2 busy pattern", {c_busy, l_busy, r_busy, i_busy}, 4'b1110);
    chk("R5 bus in load", l_bus, 8'h12);
    read_reg(4'd2, 1'b0, 1'b1, v);
    chk("R5 dest copied", v, 8'h12);
    read_reg(4'd1, 1'b0, 1'b1, v);
    chk("R5 source kept", v, 8'h12);
    run_copy(4'd1, 4'd0, 1'b0, 1'b1, 8'h80, 8'h80, 1'b0);
    chk("R5 ext OR source", l_bus, 8'h92);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    write_reg(4'd4, 8'hA5);
    run_copy(4'd0, 4'd4, 1'b0, 1'b1, 8'hFF, 8'h3C, 1'b0);
    read_reg(4'd4, 1'b0, 1'b1, v);
    chk("R4 load value only", v, 8'h3C);
  endtask

  task automatic t_code0();
    run_copy(4'd0, 4'd0, 1'b0, 1'b1, 8'h5D, 8'h5D, 1'b0);
    chk("R6 no lines", {c_el, c_er, c_clr}, 0);
    chk("R6 bus is ext", l_bus, 8'h5D);
  endtask

  task automatic t_user_mask();
    logic [7:0] v;
    write_reg(4'd9, 8'h11);
    write_reg(4'd8, 8'h22);
    run_copy(4'd0, 4'd9, 1'b0, 1'b0, 8'h55, 8'h55, 1'b0);
    chk("R7 user dest lines", {c_el, c_clr}, 0);
    read_reg(4'd9, 1'b0, 1'b1, v);
    chk("R7 user dest not stored", v, 8'h11);
    read_reg(4'd8, 1'b0, 1'b0, v);
    chk("R7 user src blocked", v, 8'h00);
    chk("R7 user src lines", c_el, 0);
  endtask

  task automatic t_status();
    logic [7:0] v;
    write_reg(4'd12, 8'h77);
    chk("R8 status clear line", c_clr, 16'h1000);
    chk("R8 status left line", c_el, 16'h1000);
    read_reg(4'd12, 1'b0, 1'b1, v);
    chk("R8 status no source", v, 8'h00);
    chk("R8 status no src line", c_el, 0);
  endtask

  task automatic t_virtual();
    logic [7:0] v;
    virt_in = 24'hC35A81;
    read_reg(4'd13, 1'b0, 1'b1, v);
    chk("R9 digit 13", v, 8'h81);
    read_reg(4'd14, 1'b0, 1'b1, v);
    chk("R9 digit 14", v, 8'h5A);
    read_reg(4'd15, 1'b0, 1'b1, v);
    chk("R9 digit 15", v, 8'hC3);
    write_reg(4'd14, 8'hEE);
    chk("R9 virtual dest lines", {c_el, c_er, c_clr}, 0);
    virt_in = 24'h000000;
  endtask

  task automatic t_right();
    logic [7:0] v;
    write_reg(4'd3, 8'h3E);
    write_reg(4'd10, 8'h44);
    write_reg(4'd11, 8'h66);
    read_reg(4'd3, 1'b1, 1'b1, v);
    chk("R10 right read", v, 8'h3E);
    chk("R10 right line", {c_er, c_el}, {16'h0008, 16'h0000});
    read_reg(4'd10, 1'b1, 1'b1, v);
    chk("R10 no right path read", v, 8'h00);
    chk("R10 no right path line", c_er, 0);
    run_copy(4'd0, 4'd11, 1'b1, 1'b1, 8'h99, 8'h99, 1'b0);
    chk("R10 no right path clear", c_clr, 0);
    read_reg(4'd11, 1'b0, 1'b1, v);
    chk("R10 no right path write", v, 8'h66);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    write_reg(4'd4, 8'h0F);
    run_copy(4'd0, 4'd5, 1'b0, 1'b1, 8'hB4, 8'hB4, 1'b1);
    chk("R11 release busy", r_busy, 1);
    chk("R11 idle after", i_busy, 0);
    @(negedge clk);
    chk("R11 stays idle", busy, 0);
    read_reg(4'd4, 1'b0, 1'b1, v);
    chk("R11 no second write", v, 8'h0F);
    read_reg(4'd5, 1'b0, 1'b1, v);
    chk("R11 first write", v, 8'hB4);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; micro = 1'b0; path_r = 1'b0;
    src_code = '0; dst_code = '0; ext_in = '0; virt_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_glitch();
    t_code0();
    t_user_mask();
    t_status();
    t_virtual();
    t_right();
    t_busy_ignore();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule